// File: doc/BRIEF.md
# Trace Capture Controller

This block records a stream of 18-bit trace items into an on-chip FIFO while capture is running. Software drives it over a small register bus with three registers. A command register starts, stops and clears capture, and it can also take a snapshot of the fill level. A status register reports the running state, a sticky flag set when the internal cycle counter wraps, and the last fill-level snapshot. A data register returns the oldest stored item, and each read of it removes that item.

Reads are registered. The word for a read strobe appears on `bus_rdata` in the cycle after the strobe. Reading the data register while the buffer is empty is an error. Such a read returns zero, leaves the buffer unchanged and raises `rd_err` for one cycle.

Top module: `trace_capture`

## Requirements
- R1: After reset the status word is all zeros, the buffer is empty, `bus_rdata` is zero and `rd_err` is low.
- R2: The register addresses are 0 for command (write-only), 1 for status and 2 for data. A read of address 0 or 3 returns zero. A write to address 1, 2 or 3 changes neither the status nor the buffer contents.
- R3: While Started is 1, each cycle with `trace_valid` high stores `trace_item` in the buffer. While Started is 0, trace input is ignored.
- R4: A read of the data register returns the oldest stored item in bits 17:0 on the next cycle and removes that item. Items come out in arrival order.
- R5: A data read while the buffer is empty returns zero, removes nothing, and pulses `rd_err` high for exactly one cycle together with that read word.
- R6: The buffer holds DEPTH (1024) items. An item that arrives while the buffer is full is dropped, even if a read happens in the same cycle.
- R7: Command bit 0 (Sample) copies the current item count into status bits 15:0. Nothing else changes that field except Clear, so the field does not track pushes or pops.
- R8: Command bit 2 (Start) sets status bit 17 (Started). Command bit 1 (Stop) clears it.
- R9: A cycle counter of CYC_W bits advances on every cycle while Started is 1. When it wraps from all ones to zero, status bit 16 (Overflow) is set and stays set through Stop and Start.
- R10: Command bit 3 (Clear) empties the buffer and zeroes Started, Overflow, the sampled count and the cycle counter.
- R11: When one command write sets several bits, they take effect in the order Clear, Stop, Start, Sample.
- R12: Bits 31:18 of every read word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| rd_err | output | 1 | One-cycle pulse for a data read of an empty buffer |
| trace_valid | input | 1 | Trace item present |
| trace_item | input | 18 | Trace item |

## Verification
A fixed-seed random phase mixes trace arrivals with data reads. It exercises simultaneous push and pop, as well as reads that find the buffer empty. This separates correct ordering and pointer handling from off-by-one errors. A directed fill past 1024 items shows whether the full case drops the extra items or overwrites old ones. Pops made after a sample and before the next sample show whether the count field is a snapshot or a live value. Multi-bit command words probe the fixed order of Clear, Stop, Start and Sample. A long run of started cycles checks that Overflow stays clear just before the counter wraps, sets just after, and holds through Stop until Clear.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  localparam int ITEM_W = 18;
  localparam int DATA_W = 32;
  localparam int SNAP_W = 16;

  typedef enum logic [1:0] {
    REG_CMD  = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic clear;
    logic start;
    logic stop;
    logic sample;
  } cmd_t;
endpackage

// File: rtl/tcap_fifo.sv
module tcap_fifo #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 18,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic             push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
    dout <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  p_full_drop_r6: assert property (@(posedge clk) disable iff (rst)
    full && push && !pop && !clr |=> count == $past(count));
  p_push_grow_r3: assert property (@(posedge clk) disable iff (rst)
    push && !full && !pop && !clr |=> count == $past(count) + 1'b1);
  p_empty_pop_r5: assert property (@(posedge clk) disable iff (rst)
    empty && pop && !push && !clr |=> empty);
endmodule

// File: rtl/tcap_ctrl.sv
module tcap_ctrl
  import tcap_pkg::*;
#(
  parameter int CYC_W = 16,
  parameter int CNT_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  cmd_t              cmd,
  input  logic [CNT_W-1:0]  live_count,
  output logic              started,
  output logic              ovf,
  output logic [SNAP_W-1:0] snap,
  output logic              fifo_clr
);
  logic [CYC_W-1:0]  cyc, cyc_n;
  logic [CYC_W:0]    cyc_inc;
  logic              st_n, ov_n;
  logic [SNAP_W-1:0] snap_n;

  assign fifo_clr = cmd_valid && cmd.clear;
  assign cyc_inc  = {1'b0, cyc} + 1'b1;

  always_comb begin
    st_n   = started;
    ov_n   = ovf;
    snap_n = snap;
    cyc_n  = cyc;
    if (started) begin
      cyc_n = cyc_inc[CYC_W-1:0];
      if (cyc_inc[CYC_W]) ov_n = 1'b1;
    end
    if (cmd_valid) begin
      if (cmd.clear) begin
        st_n   = 1'b0;
        ov_n   = 1'b0;
        snap_n = '0;
        cyc_n  = '0;
      end
      if (cmd.stop)   st_n = 1'b0;
      if (cmd.start)  st_n = 1'b1;
      if (cmd.sample) snap_n = cmd.clear ? '0 : SNAP_W'(live_count);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      started <= 1'b0;
      ovf     <= 1'b0;
      snap    <= '0;
      cyc     <= '0;
    end else begin
      started <= st_n;
      ovf     <= ov_n;
      snap    <= snap_n;
      cyc     <= cyc_n;
    end
  end

  p_start_sets_r8: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd.start |=> started);
  p_stop_clears_r8: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd.stop && !cmd.start |=> !started);
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    ovf && !(cmd_valid && cmd.clear) |=> ovf);
  p_clear_flags_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd.clear |=> !ovf && snap == '0);
  p_snap_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && (cmd.sample || cmd.clear)) |=> $stable(snap));
endmodule

// File: rtl/trace_capture.sv
module trace_capture
  import tcap_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int CYC_W  = 16,
  parameter int ADDR_W = 2,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rd_err,
  input  logic              trace_valid,
  input  logic [ITEM_W-1:0] trace_item
);
  logic              cmd_valid, data_rd, stat_rd;
  logic              started, ovf, fifo_clr;
  logic [SNAP_W-1:0] snap;
  logic [ITEM_W-1:0] dout;
  logic [CNT_W-1:0]  count;
  logic              empty, full;
  logic              sel_data_q, err_q;
  logic [DATA_W-1:0] stat_q;
  cmd_t              cmd;

  assign cmd       = cmd_t'(bus_wdata[3:0]);
  assign cmd_valid = bus_wr && (bus_addr == ADDR_W'(REG_CMD));
  assign data_rd   = bus_rd && (bus_addr == ADDR_W'(REG_DATA));
  assign stat_rd   = bus_rd && (bus_addr == ADDR_W'(REG_STAT));

  tcap_ctrl #(.CYC_W(CYC_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd),
    .live_count(count), .started(started), .ovf(ovf), .snap(snap),
    .fifo_clr(fifo_clr)
  );

  tcap_fifo #(.DEPTH(DEPTH), .WIDTH(ITEM_W)) u_fifo (
    .clk(clk), .rst(rst), .clr(fifo_clr),
    .push(started && trace_valid), .din(trace_item),
    .pop(data_rd), .dout(dout), .count(count), .empty(empty), .full(full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_data_q <= 1'b0;
      err_q      <= 1'b0;
      stat_q     <= '0;
    end else begin
      sel_data_q <= data_rd && !empty;
      err_q      <= data_rd && empty;
      stat_q     <= stat_rd ? {{(DATA_W-2-SNAP_W){1'b0}}, started, ovf, snap} : '0;
    end
  end

  assign bus_rdata = sel_data_q ? {{(DATA_W-ITEM_W){1'b0}}, dout} : stat_q;
  assign rd_err    = err_q;

  p_upper_zero_r12: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:ITEM_W] == '0);
  p_err_zero_r5: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> bus_rdata == '0);
  p_err_single_r5: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> $past(bus_rd));
endmodule

// File: tb/trace_capture_bench.sv
module trace_capture_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rd_err;
  logic        trace_valid = 1'b0;
  logic [17:0] trace_item = '0;

  int checks = 0;
  int errors = 0;

  logic [17:0] q[$];
  bit          m_started = 0, m_ovf = 0;
  int          m_snap = 0;

  always #10 clk = ~clk;

  trace_capture u_trace_capture (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rd_err(rd_err),
    .trace_valid(trace_valid), .trace_item(trace_item)
  );

  function automatic logic [31:0] exp_status();
    return {14'b0, m_started, m_ovf, 16'(m_snap)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 2'd0) begin
      if (d[3]) begin q.delete(); m_started = 0; m_ovf = 0; m_snap = 0; end
      if (d[1]) m_started = 0;
      if (d[2]) m_started = 1;
      if (d[0]) m_snap = q.size();
    end
  endtask

  task automatic read_reg(input logic [1:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(tag, bus_rdata, exp);
  endtask

  task automatic tick(input bit v, input logic [17:0] it, input bit r, input string tag);
    bit full_b, empty_b;
    logic [31:0] exp;
    full_b = (q.size() == 1024);
    empty_b = (q.size() == 0);
    trace_valid = v; trace_item = it; bus_rd = r; bus_addr = 2'd2;
    @(negedge clk);
    trace_valid = 1'b0; bus_rd = 1'b0;
    exp = '0;
    if (r) begin
      if (!empty_b) exp = {14'b0, q.pop_front()};
      check(tag, bus_rdata, exp);
      check({tag, " R5 rd_err"}, {31'b0, rd_err}, {31'b0, empty_b});
    end
    if (m_started && v && !full_b) q.push_back(it);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 rdata after reset", bus_rdata, 32'h0);
    check("R1 rd_err after reset", {31'b0, rd_err}, 32'h0);
    read_reg(2'd1, 32'h0, "R1 status after reset");

    // R3: input ignored while stopped
    for (int i = 0; i < 5; i++) tick(1'b1, 18'(i + 7), 1'b0, "R3 stopped");
    write_reg(2'd0, 32'h1);
    read_reg(2'd1, exp_status(), "R3 nothing stored while stopped");

    // R8: start
    write_reg(2'd0, 32'h4);
    read_reg(2'd1, exp_status(), "R8 started set");

    // R3/R4/R5 random mixed traffic
    for (int i = 0; i < 3000; i++)
      tick(($urandom % 2) == 0, 18'($urandom), ($urandom % 10) < 4, "R4 random read");
    while (q.size() > 0) tick(1'b0, '0, 1'b1, "R4 drain");
    tick(1'b0, '0, 1'b1, "R5 empty read");
    write_reg(2'd0, 32'h1);
    read_reg(2'd1, exp_status(), "R7 sample after drain");

    // R2: writes to non-command addresses ignored, reads of 0/3 are zero
    for (int i = 0; i < 3; i++) tick(1'b1, 18'(18'h2A000 + i), 1'b0, "R2 fill");
    write_reg(2'd1, 32'hFFFF_FFFF);
    write_reg(2'd2, 32'hFFFF_FFFF);
    write_reg(2'd3, 32'hFFFF_FFFF);
    read_reg(2'd1, exp_status(), "R2 status unchanged by writes");
    read_reg(2'd0, 32'h0, "R2 command reads zero");
    read_reg(2'd3, 32'h0, "R2 address 3 reads zero");
    for (int i = 0; i < 3; i++) tick(1'b0, '0, 1'b1, "R2 data intact");

    // R6/R7: full buffer and snapshot behaviour
    write_reg(2'd0, 32'h8);
    write_reg(2'd0, 32'h4);
    for (int i = 0; i < 1030; i++) tick(1'b1, 18'($urandom), 1'b0, "R6 fill");
    write_reg(2'd0, 32'h1);
    read_reg(2'd1, exp_status(), "R6 count saturates at 1024");
    tick(1'b1, 18'h3FFFF, 1'b1, "R6 push dropped when full with pop");
    tick(1'b0, '0, 1'b1, "R4 pop");
    tick(1'b0, '0, 1'b1, "R4 pop");
    read_reg(2'd1, exp_status(), "R7 snapshot not live");
    write_reg(2'd0, 32'h1);
    read_reg(2'd1, exp_status(), "R7 resample 1021");
    while (q.size() > 0) tick(1'b0, '0, 1'b1, "R6 drain order");
    tick(1'b0, '0, 1'b1, "R5 empty after drain");

    // R11: command ordering
    for (int i = 0; i < 5; i++) tick(1'b1, 18'(i), 1'b0, "R11 fill");
    write_reg(2'd0, 32'hF);
    read_reg(2'd1, exp_status(), "R11 clear stop start sample");
    tick(1'b0, '0, 1'b1, "R11 buffer empty after clear");
    write_reg(2'd0, 32'h6);
    read_reg(2'd1, exp_status(), "R11 start wins over stop");
    for (int i = 0; i < 4; i++) tick(1'b1, 18'(i + 100), 1'b0, "R11 fill");
    write_reg(2'd0, 32'h3);
    read_reg(2'd1, exp_status(), "R11 stop plus sample");
    write_reg(2'd0, 32'h9);
    read_reg(2'd1, exp_status(), "R10 clear plus sample gives zero");

    // R9/R10: cycle counter overflow
    write_reg(2'd0, 32'h8);
    write_reg(2'd0, 32'h4);
    repeat (65000) @(negedge clk);
    read_reg(2'd1, exp_status(), "R9 no overflow before wrap");
    repeat (1000) @(negedge clk);
    m_ovf = 1;
    read_reg(2'd1, exp_status(), "R9 overflow after wrap");
    write_reg(2'd0, 32'h2);
    write_reg(2'd0, 32'h4);
    write_reg(2'd0, 32'h2);
    read_reg(2'd1, exp_status(), "R9 overflow sticky through stop start");
    write_reg(2'd0, 32'h8);
    read_reg(2'd1, exp_status(), "R10 clear resets overflow");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule